// File: doc/BRIEF.md
# Host Periodic Pipe Interval Scheduler

This block decides, for one host-side periodic pipe (interrupt or isochronous), in which frames a token may be sent. Software programs a 3-bit interval exponent, which gives a period of 2^exponent frames. The block counts frame-start ticks while the bus is active. When the period runs out it issues a one-cycle token request, or a one-cycle skip pulse if the pipe cannot take part in a transaction at that moment. A skipped attempt is not queued. The next try comes one full period later.

Clear events act at different strengths. A hardware reset, a software reset or a wake from low-power sleep clears both the exponent and the running count. A buffer clear restarts only the count and keeps the exponent. A bus reset or suspend, shown as the bus-active enable at 0, freezes the count so that it can resume later from where it stopped.

Top module: `pipe_interval_sched`

## Requirements
- R1: With exponent e, a token request or skip pulse follows the 2^e-th counted tick after a restart, and then every 2^e counted ticks after that (e=0 gives every tick, e=7 gives every 128 ticks).
- R2: After hardware reset (`rst_n` low) both outputs are 0, the exponent is 0 and the count is at its start, so every counted tick expires.
- R3: A cycle with `sw_rst` or `wake` at 1 sets the exponent to 0 and clears the count.
- R4: While `buf_clr` is 1, ticks are not counted, no pulse is produced and the count stays at the start of the period. The exponent keeps its value, so after release a full period of 2^e ticks is counted again.
- R5: While `bus_act` is 0, ticks are ignored and the count holds. When `bus_act` returns to 1, counting resumes from the held value.
- R6: A write (`cfg_we`=1) loads `cfg_exp` and restarts the count for the new period.
- R7: With `resp_mode` at 01 (NAK) or 1x (STALL), an expiry gives `tok_skip` and not `tok_req`. Only 00 (ACK-able) allows a request.
- R8: For an IN pipe (`dir_out`=0), an expiry while `buf_empty`=0 gives `tok_skip`. The retry comes at the next expiry.
- R9: For an OUT pipe (`dir_out`=1), an expiry while `buf_empty`=1 gives `tok_skip`. The retry comes at the next expiry.
- R10: Outputs are registered. A pulse is high for exactly the one cycle after the clock edge that sampled the expiring tick. `tok_req` and `tok_skip` are never high together, and neither rises without a counted tick.
- R11: In a cycle where `sw_rst` or `wake` meets `cfg_we` or `buf_clr`, the reset wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| frame_tick | input | 1 | One-cycle frame-start tick |
| bus_act | input | 1 | Bus active enable; 0 during bus reset or suspend |
| sw_rst | input | 1 | Synchronous software reset |
| wake | input | 1 | Return from low-power sleep event |
| buf_clr | input | 1 | Buffer clear control (level) |
| cfg_we | input | 1 | Interval exponent write strobe |
| cfg_exp | input | 3 | Interval exponent to write |
| resp_mode | input | 2 | Pipe response: 00 ACK-able, 01 NAK, 1x STALL |
| dir_out | input | 1 | Transfer direction: 1 OUT, 0 IN |
| buf_empty | input | 1 | Pipe buffer holds no data |
| tok_req | output | 1 | Token issue request pulse |
| tok_skip | output | 1 | Expiry skipped, retry at next interval |

## Verification
The bench works through the cases where clear events differ:
- A buffer clear must keep the exponent. A design that also zeroed the exponent would start requesting on every tick.
- A freeze must resume the count rather than restart it. A design that reloaded the count would delay the request by a full period.
- A software reset or wake must drop a write made in the same cycle. A design that honoured the write would keep the long period.

The bench also checks each ineligible case (NAK, both STALL codes, a full IN buffer, an empty OUT buffer) and then confirms that the retry comes one full period later and not on the next tick.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef enum logic [1:0] {
    RESP_ACK       = 2'b00,
    RESP_NAK       = 2'b01,
    RESP_STALL     = 2'b10,
    RESP_STALL_ALT = 2'b11
  } resp_e;

endpackage

// File: rtl/pis_cfg_reg.sv
module pis_cfg_reg #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_clr,
  input  logic             we,
  input  logic [EXP_W-1:0] din,
  output logic [EXP_W-1:0] q,
  output logic [EXP_W-1:0] q_next
);

  logic             en;

  always_comb begin
    en     = hard_clr | we;
    q_next = q;
    if (hard_clr) begin
      q_next = '0;
    end else if (we) begin
      q_next = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/pis_ivl_cnt.sv
module pis_ivl_cnt #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_clr,
  input  logic             restart,
  input  logic             run,
  input  logic [EXP_W-1:0] cur_exp,
  input  logic [EXP_W-1:0] load_exp,
  output logic             expire
);

  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Period minus one: ones in the low e bits.
  function automatic logic [CNT_W-1:0] span_m1(input logic [EXP_W-1:0] e);
    return ~({CNT_W{1'b1}} << e);
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = hard_clr | restart | run;
    if (hard_clr) begin
      cnt_d = '0;
    end else if (restart) begin
      cnt_d = span_m1(load_exp);
    end else if (run) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = span_m1(cur_exp);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pis_gate.sv
module pis_gate
  import pis_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  expire,
  input  resp_e resp,
  input  logic  dir_out,
  input  logic  buf_empty,
  output logic  tok_req,
  output logic  tok_skip
);

  logic elig;
  logic req_d;
  logic skip_d;

  always_comb begin
    elig   = (resp == RESP_ACK) && (dir_out ? !buf_empty : buf_empty);
    req_d  = expire & elig;
    skip_d = expire & ~elig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_req  <= 1'b0;
      tok_skip <= 1'b0;
    end else begin
      tok_req  <= req_d;
      tok_skip <= skip_d;
    end
  end

endmodule

// File: rtl/pipe_interval_sched.sv
module pipe_interval_sched
  import pis_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             bus_act,
  input  logic             sw_rst,
  input  logic             wake,
  input  logic             buf_clr,
  input  logic             cfg_we,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic [1:0]       resp_mode,
  input  logic             dir_out,
  input  logic             buf_empty,
  output logic             tok_req,
  output logic             tok_skip
);

  logic             hard_clr;
  logic             restart;
  logic             run;
  logic             expire;
  logic [EXP_W-1:0] exp_q;
  logic [EXP_W-1:0] exp_next;
  resp_e            resp;

  assign hard_clr = sw_rst | wake;
  assign restart  = buf_clr | cfg_we;
  assign run      = frame_tick & bus_act;
  assign resp     = resp_e'(resp_mode);

  pis_cfg_reg #(.EXP_W(EXP_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .hard_clr (hard_clr),
    .we       (cfg_we),
    .din      (cfg_exp),
    .q        (exp_q),
    .q_next   (exp_next)
  );

  pis_ivl_cnt #(.EXP_W(EXP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hard_clr (hard_clr),
    .restart  (restart),
    .run      (run),
    .cur_exp  (exp_q),
    .load_exp (exp_next),
    .expire   (expire)
  );

  pis_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .resp      (resp),
    .dir_out   (dir_out),
    .buf_empty (buf_empty),
    .tok_req   (tok_req),
    .tok_skip  (tok_skip)
  );

endmodule

// File: rtl/pis_checker.sv
module pis_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       bus_act,
  input logic       sw_rst,
  input logic       wake,
  input logic       buf_clr,
  input logic [1:0] resp_mode,
  input logic       dir_out,
  input logic       buf_empty,
  input logic       tok_req,
  input logic       tok_skip
);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_req && tok_skip));

  a_r10_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_tick && bus_act) |=> !tok_req && !tok_skip);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_act |=> !tok_req && !tok_skip);

  a_r4_bufclr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> !tok_req && !tok_skip);

  a_r3_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst || wake) |=> !tok_req && !tok_skip);

  a_r7_nak_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && resp_mode != 2'b00) |=> !tok_req);

  a_r8_in_full: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !dir_out && !buf_empty) |=> !tok_req);

  a_r9_out_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && dir_out && buf_empty) |=> !tok_req);

endmodule

bind pipe_interval_sched pis_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .bus_act    (bus_act),
  .sw_rst     (sw_rst),
  .wake       (wake),
  .buf_clr    (buf_clr),
  .resp_mode  (resp_mode),
  .dir_out    (dir_out),
  .buf_empty  (buf_empty),
  .tok_req    (tok_req),
  .tok_skip   (tok_skip)
);

// File: tb/pipe_interval_sched_bench.sv
`timescale 1ns/1ps
module pipe_interval_sched_bench;

  logic       clk;
  logic       rst_n;
  logic       frame_tick;
  logic       bus_act;
  logic       sw_rst;
  logic       wake;
  logic       buf_clr;
  logic       cfg_we;
  logic [2:0] cfg_exp;
  logic [1:0] resp_mode;
  logic       dir_out;
  logic       buf_empty;
  logic       tok_req;
  logic       tok_skip;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  pipe_interval_sched u_pipe_interval_sched (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bus_act(bus_act),
    .sw_rst(sw_rst), .wake(wake), .buf_clr(buf_clr), .cfg_we(cfg_we),
    .cfg_exp(cfg_exp), .resp_mode(resp_mode), .dir_out(dir_out),
    .buf_empty(buf_empty), .tok_req(tok_req), .tok_skip(tok_skip)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual run still going, expected end");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string tag, logic er, logic es);
    n_chk++;
    if (tok_req !== er || tok_skip !== es) begin
      n_fail++;
      $display("FAIL %s: actual req=%b skip=%b, expected req=%b skip=%b",
               tag, tok_req, tok_skip, er, es);
    end
  endtask

  // Called at a negedge: one cycle with a tick, sample at the next negedge.
  task automatic tick(string tag, logic er, logic es);
    frame_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_tick = 1'b0;
    check(tag, er, es);
  endtask

  task automatic idle(string tag);
    @(posedge clk); @(negedge clk);
    check(tag, 1'b0, 1'b0);
  endtask

  task automatic set_exp(logic [2:0] e);
    cfg_we = 1'b1; cfg_exp = e;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic eligible_in();
    resp_mode = 2'b00; dir_out = 1'b0; buf_empty = 1'b1; bus_act = 1'b1;
  endtask

  task automatic t_reset();
    check("R2 reset outputs", 1'b0, 1'b0);
    eligible_in();
    for (int i = 0; i < 3; i++) tick("R2 exp0 every tick", 1'b1, 1'b0);
  endtask

  task automatic t_interval();
    set_exp(3'd2);
    for (int i = 1; i <= 8; i++)
      tick("R1 R6 period 4", (i % 4) == 0, 1'b0);
    idle("R10 single cycle pulse");
    set_exp(3'd7);
    for (int i = 1; i <= 128; i++)
      if (i == 127 || i == 128) tick("R1 period 128", i == 128, 1'b0);
      else begin frame_tick = 1'b1; @(posedge clk); @(negedge clk); frame_tick = 1'b0; end
  endtask

  task automatic t_freeze();
    set_exp(3'd2);
    tick("R5 pre 1", 1'b0, 1'b0);
    tick("R5 pre 2", 1'b0, 1'b0);
    bus_act = 1'b0;
    for (int i = 0; i < 5; i++) tick("R5 frozen", 1'b0, 1'b0);
    bus_act = 1'b1;
    tick("R5 resume 3", 1'b0, 1'b0);
    tick("R5 resume 4", 1'b1, 1'b0);
  endtask

  task automatic t_bufclr();
    set_exp(3'd2);
    for (int i = 0; i < 3; i++) tick("R4 pre", 1'b0, 1'b0);
    buf_clr = 1'b1;
    tick("R4 held", 1'b0, 1'b0);
    tick("R4 held", 1'b0, 1'b0);
    buf_clr = 1'b0;
    for (int i = 1; i <= 4; i++) tick("R4 full period after release", i == 4, 1'b0);
  endtask

  task automatic t_swrst_wake();
    set_exp(3'd2);
    tick("R3 pre", 1'b0, 1'b0);
    sw_rst = 1'b1; @(posedge clk); @(negedge clk); sw_rst = 1'b0;
    tick("R3 sw reset exp0", 1'b1, 1'b0);
    set_exp(3'd3);
    tick("R3 pre wake", 1'b0, 1'b0);
    wake = 1'b1; @(posedge clk); @(negedge clk); wake = 1'b0;
    tick("R3 wake exp0", 1'b1, 1'b0);
  endtask

  task automatic t_priority();
    sw_rst = 1'b1; cfg_we = 1'b1; cfg_exp = 3'd3; buf_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    sw_rst = 1'b0; cfg_we = 1'b0; buf_clr = 1'b0;
    tick("R11 reset beats write", 1'b1, 1'b0);
    tick("R11 reset beats write again", 1'b1, 1'b0);
  endtask

  task automatic t_resp();
    set_exp(3'd0);
    resp_mode = 2'b01; tick("R7 NAK skip", 1'b0, 1'b1);
    resp_mode = 2'b10; tick("R7 STALL skip", 1'b0, 1'b1);
    resp_mode = 2'b11; tick("R7 STALL alt skip", 1'b0, 1'b1);
    resp_mode = 2'b00; tick("R7 ACK request", 1'b1, 1'b0);
  endtask

  task automatic t_dir();
    set_exp(3'd1);
    buf_empty = 1'b0;
    tick("R8 IN t1", 1'b0, 1'b0);
    tick("R8 IN full skip", 1'b0, 1'b1);
    buf_empty = 1'b1;
    tick("R8 no early retry", 1'b0, 1'b0);
    tick("R8 retry next interval", 1'b1, 1'b0);
    dir_out = 1'b1;
    tick("R9 OUT t1", 1'b0, 1'b0);
    tick("R9 OUT empty skip", 1'b0, 1'b1);
    buf_empty = 1'b0;
    tick("R9 no early retry", 1'b0, 1'b0);
    tick("R9 retry next interval", 1'b1, 1'b0);
    idle("R10 no tick no pulse");
  endtask

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; bus_act = 1'b0; sw_rst = 1'b0;
    wake = 1'b0; buf_clr = 1'b0; cfg_we = 1'b0; cfg_exp = 3'd0;
    resp_mode = 2'b00; dir_out = 1'b0; buf_empty = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval();
    t_freeze();
    t_bufclr();
    t_swrst_wake();
    t_priority();
    t_resp();
    eligible_in();
    t_dir();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule